// File: doc/BRIEF.md
# Channel Gain Scaler with Round and Clip

This block multiplies a stream of signed 16-bit complex samples (I and Q) by a programmable unsigned gain. It is meant for evening out the amplitude droop that sampling and analogue stages add to one channel, before that channel joins others further down the chain. The gain is an 8-bit code read as a fixed-point number with one integer bit and seven fraction bits. Code 0x80 is unity and code 0x00 silences the channel.

The product is brought back to 16 bits by adding half an output LSB and dropping the seven fraction bits. A result that falls outside the signed 16-bit range is pinned to the nearest limit. Both lanes share one gain value but are scaled by separate arithmetic. Each output sample is registered one clock after its input, and a valid flag goes with it.

Top module: `chan_gain_scaler`

## Requirements
- R1: After reset the gain code is 0x80 (scale 1.0), so a valid input leaves the block unchanged.
- R2: A gain write (gain_we high with gain_wdata) affects samples presented in later cycles. A sample presented in the same cycle as the write is scaled with the previous gain.
- R3: Each lane output equals the signed input times code/128. The code is unsigned, so the range is 0 to 255/128 in steps of 1/128.
- R4: Rounding adds 64 to the 24-bit product before an arithmetic shift right by 7, so a half-LSB tie rounds toward positive infinity (+0.5 gives 1, -0.5 gives 0).
- R5: A rounded result above 32767 is output as 0x7FFF.
- R6: A rounded result below -32768 is output as 0x8000.
- R7: Gain code 0x00 makes both outputs zero for any input.
- R8: I and Q are scaled independently with the same gain. A clip on one lane does not alter the other.
- R9: out_valid equals in_valid delayed by one clock. out_i and out_q keep their last value while no valid input arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gain_we | input | 1 | Gain write strobe |
| gain_wdata | input | 8 | Gain code, unsigned with 7 fraction bits |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Scaled in-phase sample, signed |
| out_q | output | 16 | Scaled quadrature sample, signed |

## Verification
The only internal state is the stored gain code and the output registers, so a corrupted gain shows up at the ports on the very next valid sample as a wrong product. A wrong reset value shows up at once as a non-unity result on the first sample after reset. A wrong rounding constant or clip limit shows only on ties and on extreme inputs, so the directed cases aim at exact half-LSB products and at full-scale inputs under large gains. Every error reaches the outputs exactly one clock after the offending input.

// File: rtl/gain_scl_pkg.sv
package gain_scl_pkg;
  localparam int unsigned LANES = 2;
  localparam int unsigned LANE_I = 0;
  localparam int unsigned LANE_Q = 1;
endpackage

// File: rtl/gain_code_reg.sv
module gain_code_reg #(
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned FRAC_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [GAIN_W-1:0] wdata,
  output logic [GAIN_W-1:0] code
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

  always_ff @(posedge clk) begin
    if (rst)     code <= UNITY;
    else if (we) code <= wdata;
  end

  // R1
  reset_unity_chk: assert property (@(posedge clk) $fell(rst) |-> code == UNITY);
  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> code == $past(wdata));
endmodule

// File: rtl/gain_lane.sv
module gain_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned FRAC_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld,
  input  logic [GAIN_W-1:0]        code,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);
  localparam int unsigned PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] MAXV   = PROD_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV   = -(PROD_W'(1) <<< (DATA_W - 1));
  localparam logic [DATA_W-1:0]        POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0]        NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rnd;
  logic signed [DATA_W-1:0] clipped;

  always_comb begin
    prod = PROD_W'(din) * $signed({1'b0, code});
    rnd  = (prod + HALF) >>> FRAC_W;
    if (rnd > MAXV)      clipped = POS_FS;
    else if (rnd < MINV) clipped = NEG_FS;
    else                 clipped = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (vld) dout <= clipped;
  end

  // R3
  sign_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && !din[DATA_W-1]) |=> !dout[DATA_W-1]);
  // R7
  mute_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && code == '0) |=> dout == '0);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(dout));
endmodule

// File: rtl/chan_gain_scaler.sv
module chan_gain_scaler #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned FRAC_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gain_we,
  input  logic [GAIN_W-1:0] gain_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  import gain_scl_pkg::*;

  logic [GAIN_W-1:0] code;
  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_out [LANES];

  gain_code_reg #(.GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_code (
    .clk(clk), .rst(rst), .we(gain_we), .wdata(gain_wdata), .code(code)
  );

  assign lane_in[LANE_I] = in_i;
  assign lane_in[LANE_Q] = in_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gain_lane #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_lane (
      .clk(clk), .rst(rst), .vld(in_valid), .code(code),
      .din(lane_in[l]), .dout(lane_out[l])
    );
  end

  assign out_i = lane_out[LANE_I];
  assign out_q = lane_out[LANE_Q];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));
  // R1
  unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && code == (GAIN_W'(1) << FRAC_W)) |=> out_i == $past(in_i) && out_q == $past(in_q));
endmodule

// File: tb/test_chan_gain_scaler.sv
module test_chan_gain_scaler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gain_we = 1'b0;
  logic [7:0]  gain_wdata = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_i = '0;
  logic [15:0] in_q = '0;
  logic        out_valid;
  logic [15:0] out_i;
  logic [15:0] out_q;

  int n_chk = 0;
  int n_bad = 0;
  int model_gain = 128;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_gain_scaler i_chan_gain_scaler (
    .clk(clk), .rst(rst), .gain_we(gain_we), .gain_wdata(gain_wdata),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic int expv(int x, int g);
    int p;
    p = (x * g + 64) >>> 7;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_gain(int g);
    @(negedge clk);
    gain_we = 1'b1; gain_wdata = 8'(g);
    @(negedge clk);
    gain_we = 1'b0;
    model_gain = g;
  endtask

  task automatic send(string req, int xi, int xq);
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, int'(out_valid), 1);
    chk(req, int'($signed(out_i)), expv(xi, model_gain));
    chk(req, int'($signed(out_q)), expv(xq, model_gain));
  endtask

  task automatic t_reset;
    chk("R9 reset valid", int'(out_valid), 0);
    chk("R9 reset data", int'(out_i), 0);
    send("R1 unity", 12345, -23456);
    send("R1 unity full scale", 32767, -32768);
  endtask

  task automatic t_scale;
    wr_gain(96);
    send("R3 gain 0.75", 1000, -1000);
    wr_gain(255);
    send("R3 gain max", 100, -7);
    wr_gain(1);
    send("R3 gain min", 20000, -20000);
  endtask

  task automatic t_round;
    wr_gain(64);
    send("R4 tie pos", 1, -1);
    send("R4 tie odd", 3, -3);
    wr_gain(192);
    send("R4 mixed", 5, -5);
  endtask

  task automatic t_sat;
    wr_gain(255);
    send("R5 clip pos", 32767, 20000);
    send("R6 clip neg", -32768, -20000);
    send("R8 lanes split", 32767, 100);
    wr_gain(129);
    send("R5 edge", 32512, -32512);
  endtask

  task automatic t_mute;
    wr_gain(0);
    send("R7 mute", 32767, -32768);
    send("R7 mute small", -1, 1);
  endtask

  task automatic t_timing;
    int hi, hq;
    wr_gain(128);
    // R2: write and sample in the same cycle use the old gain
    @(negedge clk);
    gain_we = 1'b1; gain_wdata = 8'd64;
    in_valid = 1'b1; in_i = 16'd400; in_q = 16'd800;
    @(negedge clk);
    gain_we = 1'b0; in_valid = 1'b0;
    chk("R2 old gain i", int'($signed(out_i)), 400);
    chk("R2 old gain q", int'($signed(out_q)), 800);
    model_gain = 64;
    send("R2 new gain", 400, 800);
    // R9: outputs held while idle
    hi = int'($signed(out_i)); hq = int'($signed(out_q));
    in_i = 16'd7; in_q = 16'd9;
    repeat (3) @(negedge clk);
    chk("R9 idle valid", int'(out_valid), 0);
    chk("R9 hold i", int'($signed(out_i)), hi);
    chk("R9 hold q", int'($signed(out_q)), hq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_scale();
    t_round();
    t_sat();
    t_mute();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule